// File: doc/BRIEF.md
# RS485 Transmit Path with Automatic Driver Enable

This block serialises bytes onto a half-duplex multidrop RS485 bus and controls the line transceiver's driver enable (`de`) by itself. Bytes enter through a small queue with a valid/ready handshake. Each byte leaves as one start bit (low), eight data bits with the least significant bit first, and one stop bit (high). The bit time is a programmable number of clocks.

The node takes the bus only when it needs it. Before the first start bit, `de` rises and the line is held at mark for a lead-in period. The driver stays on until the queue is empty and the final stop bit has fully elapsed. A further hold-off interval then follows. After that, `de` drops and a one-clock `tx_done` pulse marks the release.

A break request sends a long low period, and the driver stays enabled for the whole of it. A turnaround guard, fed by the receiver's line-idle indication, blocks new bus acquisition until the bus has been quiet for a programmed time. This gives a remote node time to turn off its own driver.

Top module: `rs485_tx_dirctl`

## Requirements
- R1: After reset, `de` is low, `tx` is high, `tx_done` is low and `in_ready` is high.
- R2: Each byte appears on `tx` as a low start bit, eight data bits least significant first, and a high stop bit. Every bit lasts `cfg_div` clocks, where `cfg_div` is at least 1.
- R3: `de` rises `cfg_lead` bit times (`cfg_lead` at least 1) before the first start bit, with `tx` high during that time. `tx` is never low while `de` is low.
- R4: For a lone byte, `de` stays high for exactly (`cfg_lead` + 10) × `cfg_div` + `cfg_hold` + 1 clocks. This covers the whole stop bit plus `cfg_hold` + 1 clocks after it. `de` falls only while `tx` is high.
- R5: Bytes that are queued, or that arrive during the hold-off, are sent without dropping `de`. One release follows the last of them.
- R6: `tx_done` is high for exactly one clock, in the first cycle in which `de` is low after being high. Every fall of `de` has such a pulse.
- R7: A byte is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low while the queue holds `DEPTH` bytes.
- R8: While `line_idle` is low, `de` does not rise. After `line_idle` goes high and stays high, `de` rises on the (`cfg_guard` + 1)-th clock edge, provided work is pending.
- R9: A one-clock pulse on `brk_req` produces a low period of `cfg_brk_bits` × `cfg_div` clocks with `de` high. The line then returns high for at least one bit time before `de` falls. With an empty queue, `de` stays high for (`cfg_lead` + `cfg_brk_bits` + 1) × `cfg_div` + `cfg_hold` + 1 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_data | input | 8 | Byte to queue |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | Queue has room |
| cfg_div | input | 16 | Clocks per bit |
| cfg_lead | input | 8 | Lead-in bit times before the first start bit |
| cfg_hold | input | 16 | Extra clocks after the last stop bit before release |
| cfg_brk_bits | input | 8 | Break length in bit times |
| cfg_guard | input | 16 | Quiet clocks required after line activity |
| brk_req | input | 1 | Pulse to request a break |
| line_idle | input | 1 | Receiver reports no activity on the bus |
| tx | output | 1 | Serial data to the transceiver |
| de | output | 1 | Transceiver driver enable |
| tx_done | output | 1 | One-clock pulse on driver release |

## Verification
The checker watches several rules on every cycle:
- `tx` stays high while the driver is off.
- A start bit or break only begins after `de` was already high.
- `de` falls only from a mark level, and always together with a `tx_done` pulse.
- A busy line never lets `de` rise.

Other properties are shown only by the bench's scenarios, which count cycles and decode bytes:
- the exact lead-in and hold-off lengths;
- the bit order and bit timing of each frame;
- one release for a burst, or for a byte that arrives during the hold-off;
- the exact guard delay;
- the break length.

// File: rtl/rs485_tx_pkg.sv
// Shared types for the RS485 transmit path.
package rs485_tx_pkg;
    // Sequencer states; anything other than ST_IDLE owns the bus.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_BRK,
        ST_BRKEND,
        ST_HOLD
    } txst_e;
endpackage

// File: rtl/rs485_txq.sv
// Byte queue with valid/ready write side and pop/head read side.
// Assumes pop is only asserted while the queue is not empty.
module rs485_txq #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] wr_data,
    input  logic         wr_valid,
    output logic         wr_ready,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          wr_en;

    assign wr_ready = (cnt != CW'(DEPTH));
    assign empty    = (cnt == '0);
    assign wr_en    = wr_valid && wr_ready;
    assign head     = mem[rp];

    // Storage write.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wp] <= wr_data;
    end

    // Pointer and occupancy update with explicit wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (wr_en) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (pop)   rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            if (wr_en && !pop)      cnt <= cnt + 1'b1;
            else if (!wr_en && pop) cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/rs485_bitclk.sv
// Bit-period timer: pulses tick on the last clock of every bit time.
// restart holds the phase at zero so the next bit begins cleanly.
module rs485_bitclk #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] div_eff;

    assign div_eff = (div == '0) ? DIV_W'(1) : div;
    assign tick    = !restart && (cnt == div_eff - 1'b1);

    // Phase counter within the current bit.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || tick) cnt <= '0;
        else                           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rs485_guard.sv
// Turnaround guard: reloads while the line is busy, counts down while quiet.
// clear is high once the line has been quiet for the programmed clocks.
module rs485_guard #(
    parameter int GW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_idle,
    input  logic [GW-1:0] cfg_guard,
    output logic          clear
);
    logic [GW-1:0] cnt;

    assign clear = line_idle && (cnt == '0);

    // Reload on activity, count down on quiet.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (!line_idle)   cnt <= cfg_guard;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/rs485_txseq.sv
// Frame sequencer: owns the driver enable, the lead-in, the shift register,
// the break, the post-frame hold-off and the release pulse.
// Assumes tick comes from a bit timer restarted by this module's restart.
module rs485_txseq #(
    parameter int W   = 8,
    parameter int HW  = 16,
    parameter int BW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          q_empty,
    input  logic [W-1:0]  q_head,
    input  logic          go_ok,
    input  logic          brk_req,
    input  logic [BW-1:0] cfg_lead,
    input  logic [BW-1:0] cfg_brk_bits,
    input  logic [HW-1:0] cfg_hold,
    output logic          q_pop,
    output logic          restart,
    output logic          tx,
    output logic          de,
    output logic          tx_done
);
    import rs485_tx_pkg::*;

    localparam int LAST_BIT = W - 1;

    txst_e         st, st_n;
    logic [BW-1:0] bitn;
    logic [W-1:0]  shreg;
    logic [HW-1:0] hcnt;
    logic          brk_pend;
    logic          done_q;
    logic [BW-1:0] lead_eff, brk_eff;
    logic          to_start, to_brk, to_idle;

    assign lead_eff = (cfg_lead == '0) ? BW'(1) : cfg_lead;
    assign brk_eff  = (cfg_brk_bits == '0) ? BW'(1) : cfg_brk_bits;

    // Next-state selection; to_start also pops the queue.
    always_comb begin
        st_n     = st;
        to_start = 1'b0;
        to_brk   = 1'b0;
        to_idle  = 1'b0;
        unique case (st)
            ST_IDLE:  if ((!q_empty || brk_pend) && go_ok) st_n = ST_LEAD;
            ST_LEAD:  if (tick && bitn == lead_eff - 1'b1) begin
                          if (brk_pend) to_brk = 1'b1;
                          else          to_start = 1'b1;
                      end
            ST_START: if (tick) st_n = ST_DATA;
            ST_DATA:  if (tick && bitn == BW'(LAST_BIT)) st_n = ST_STOP;
            ST_BRK:   if (tick && bitn == brk_eff - 1'b1) st_n = ST_BRKEND;
            ST_STOP, ST_BRKEND: if (tick) begin
                          if (brk_pend)      to_brk = 1'b1;
                          else if (!q_empty) to_start = 1'b1;
                          else               st_n = ST_HOLD;
                      end
            ST_HOLD:  begin
                          if (brk_pend)              to_brk = 1'b1;
                          else if (!q_empty)         to_start = 1'b1;
                          else if (hcnt == cfg_hold) to_idle = 1'b1;
                      end
            default:  st_n = ST_IDLE;
        endcase
        if (to_start) st_n = ST_START;
        if (to_brk)   st_n = ST_BRK;
        if (to_idle)  st_n = ST_IDLE;
    end

    assign q_pop   = to_start;
    assign restart = (st == ST_IDLE) || (st == ST_HOLD);

    // State, bit counter, shifter, hold-off counter and release pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            bitn   <= '0;
            shreg  <= '0;
            hcnt   <= '0;
            done_q <= 1'b0;
        end else begin
            st     <= st_n;
            done_q <= to_idle;
            if (st_n != st) bitn <= '0;
            else if (tick && (st == ST_LEAD || st == ST_DATA || st == ST_BRK))
                bitn <= bitn + 1'b1;
            if (to_start)                    shreg <= q_head;
            else if (st == ST_DATA && tick)  shreg <= shreg >> 1;
            if (st == ST_HOLD) hcnt <= hcnt + 1'b1;
            else               hcnt <= '0;
        end
    end

    // Break request latch, cleared when the break begins.
    always_ff @(posedge clk) begin
        if (!rst_n)       brk_pend <= 1'b0;
        else if (to_brk)  brk_pend <= 1'b0;
        else if (brk_req) brk_pend <= 1'b1;
    end

    // Line level per state.
    always_comb begin
        unique case (st)
            ST_START, ST_BRK: tx = 1'b0;
            ST_DATA:          tx = shreg[0];
            default:          tx = 1'b1;
        endcase
    end

    assign de      = (st != ST_IDLE);
    assign tx_done = done_q;
endmodule

// File: rtl/rs485_tx_dirctl.sv
// RS485 transmit path top: queue, bit timer, turnaround guard and sequencer.
// Assumes line_idle is already synchronous to clk.
module rs485_tx_dirctl #(
    parameter int DEPTH = 4,
    parameter int DW    = 8,
    parameter int DIV_W = 16,
    parameter int HW    = 16,
    parameter int BW    = 8,
    parameter int GW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DW-1:0]    in_data,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [BW-1:0]    cfg_lead,
    input  logic [HW-1:0]    cfg_hold,
    input  logic [BW-1:0]    cfg_brk_bits,
    input  logic [GW-1:0]    cfg_guard,
    input  logic             brk_req,
    input  logic             line_idle,
    output logic             tx,
    output logic             de,
    output logic             tx_done
);
    logic          q_pop, q_empty, tick, restart, go_ok;
    logic [DW-1:0] q_head;

    rs485_txq #(.W(DW), .DEPTH(DEPTH)) u_q (
        .clk(clk), .rst_n(rst_n),
        .wr_data(in_data), .wr_valid(in_valid), .wr_ready(in_ready),
        .pop(q_pop), .head(q_head), .empty(q_empty)
    );

    rs485_bitclk #(.DIV_W(DIV_W)) u_bit (
        .clk(clk), .rst_n(rst_n), .restart(restart), .div(cfg_div), .tick(tick)
    );

    rs485_guard #(.GW(GW)) u_guard (
        .clk(clk), .rst_n(rst_n), .line_idle(line_idle),
        .cfg_guard(cfg_guard), .clear(go_ok)
    );

    rs485_txseq #(.W(DW), .HW(HW), .BW(BW)) u_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .q_empty(q_empty), .q_head(q_head), .go_ok(go_ok),
        .brk_req(brk_req), .cfg_lead(cfg_lead), .cfg_brk_bits(cfg_brk_bits),
        .cfg_hold(cfg_hold), .q_pop(q_pop), .restart(restart),
        .tx(tx), .de(de), .tx_done(tx_done)
    );
endmodule

// File: rtl/rs485_tx_dirctl_chk.sv
// Port-level rules for the RS485 transmit path, bound into the top.
module rs485_tx_dirctl_chk (
    input logic clk,
    input logic rst_n,
    input logic tx,
    input logic de,
    input logic tx_done,
    input logic line_idle
);
    a_r3_line_high_when_released: assert property (@(posedge clk) disable iff (!rst_n)
        !de |-> tx);

    a_r3_low_only_after_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx) |-> $past(de));

    a_r4_release_from_mark: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(de) |-> $past(tx));

    a_r6_done_marks_release: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> (!de && $past(de)));

    a_r6_release_flags_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(de) |-> tx_done);

    a_r8_busy_line_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_idle && !de) |=> !de);
endmodule

bind rs485_tx_dirctl rs485_tx_dirctl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tx(tx), .de(de),
    .tx_done(tx_done), .line_idle(line_idle)
);

// File: tb/rs485_tx_dirctl_test.sv
`timescale 1ns/1ps
module rs485_tx_dirctl_test;
    localparam int DIV   = 8;
    localparam int LEAD  = 2;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] cfg_div = 16'(DIV);
    logic [7:0]  cfg_lead = 8'(LEAD);
    logic [15:0] cfg_hold = 16'd5;
    logic [7:0]  cfg_brk_bits = 8'd3;
    logic [15:0] cfg_guard = 16'd20;
    logic        brk_req = 1'b0;
    logic        line_idle = 1'b1;
    logic        tx, de, tx_done;

    int n_chk = 0, n_bad = 0;
    int cyc = 0, de_start = 0, lead_meas = 0, de_len = 0, low_start = 0, last_low = 0;
    int episodes = 0, done_cnt = 0, mon_bad = 0;
    bit got_fall = 0, prev_de = 0, prev_tx = 1;
    bit rx_on = 1, rbusy = 0;
    int rcnt = 0, rx_n = 0, rx_ferr = 0;
    logic [7:0] rbyte;
    logic [7:0] rx_buf [16];

    always #2.5 clk = ~clk;

    rs485_tx_dirctl uut (.*);

    // Negedge monitor: timing of de/tx plus a UART receiver model.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (de && !prev_de) begin de_start = cyc; got_fall = 0; end
            if (!de && prev_de) begin de_len = cyc - de_start; episodes++; end
            if (!tx && prev_tx) begin
                low_start = cyc;
                if (!got_fall) begin lead_meas = cyc - de_start; got_fall = 1; end
            end
            if (tx && !prev_tx) last_low = cyc - low_start;
            if (tx_done) begin
                done_cnt++;
                if (de || !prev_de) mon_bad++;
            end
            if (!de && !tx) mon_bad++;
            if (rx_on) begin
                if (!rbusy) begin
                    if (prev_tx && !tx) begin rbusy = 1; rcnt = 0; end
                end else begin
                    rcnt++;
                    if (rcnt >= DIV/2 && (rcnt - DIV/2) % DIV == 0) begin
                        automatic int k = (rcnt - DIV/2) / DIV;
                        if (k >= 1 && k <= 8) rbyte[k-1] = tx;
                        if (k == 9) begin
                            if (tx) begin rx_buf[rx_n % 16] = rbyte; rx_n++; end
                            else rx_ferr++;
                            rbusy = 0;
                        end
                    end
                end
            end
        end
        prev_de = de;
        prev_tx = tx;
    end

    task automatic check(input string req, input bit ok, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        bit was_ready;
        @(negedge clk);
        in_data = b; in_valid = 1'b1;
        forever begin
            was_ready = in_ready;
            @(negedge clk);
            if (was_ready) break;
        end
        in_valid = 1'b0;
    endtask

    task automatic wait_release(input int ep0);
        int t = 0;
        while (episodes == ep0 && t < 5000) begin @(negedge clk); t++; end
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 de", de == 0, de, 0);
        check("R1 tx", tx == 1, tx, 1);
        check("R1 tx_done", tx_done == 0, tx_done, 0);
        check("R1 in_ready", in_ready == 1, in_ready, 1);
    endtask

    task automatic t_single();
        int ep0 = episodes, n0 = rx_n, d0 = done_cnt;
        push(8'hA5);
        wait_release(ep0);
        check("R2 byte count", rx_n == n0 + 1, rx_n - n0, 1);
        check("R2 byte value", rx_buf[n0 % 16] == 8'hA5, rx_buf[n0 % 16], 8'hA5);
        check("R3 lead-in", lead_meas == LEAD * DIV, lead_meas, LEAD * DIV);
        check("R4 de length", de_len == (LEAD + 10) * DIV + 5 + 1, de_len, (LEAD + 10) * DIV + 6);
        check("R6 one done pulse", done_cnt == d0 + 1, done_cnt - d0, 1);
    endtask

    task automatic t_burst();
        int ep0 = episodes, n0 = rx_n;
        @(negedge clk); line_idle = 1'b0;
        push(8'h01); push(8'h80); push(8'h3C);
        @(negedge clk); line_idle = 1'b1;
        wait_release(ep0);
        check("R5 one release", episodes == ep0 + 1, episodes - ep0, 1);
        check("R5 byte0", rx_buf[n0 % 16] == 8'h01, rx_buf[n0 % 16], 8'h01);
        check("R5 byte1", rx_buf[(n0 + 1) % 16] == 8'h80, rx_buf[(n0 + 1) % 16], 8'h80);
        check("R5 byte2", rx_buf[(n0 + 2) % 16] == 8'h3C, rx_buf[(n0 + 2) % 16], 8'h3C);
        check("R5 de length", de_len == (LEAD + 30) * DIV + 6, de_len, (LEAD + 30) * DIV + 6);
    endtask

    task automatic t_guard();
        int ep0 = episodes, n0 = rx_n, n = 0;
        @(negedge clk); line_idle = 1'b0;
        for (int i = 0; i < DEPTH; i++) push(8'(8'h10 + i));
        @(negedge clk);
        check("R7 ready low when full", in_ready == 0, in_ready, 0);
        repeat (50) @(negedge clk);
        check("R8 no de on busy line", de == 0 && episodes == ep0, de, 0);
        line_idle = 1'b1;
        while (!de && n < 1000) begin @(negedge clk); n++; end
        check("R8 guard delay", n == 21, n, 21);
        wait_release(ep0);
        check("R7 all bytes sent", rx_n == n0 + DEPTH, rx_n - n0, DEPTH);
        check("R7 last byte", rx_buf[(n0 + 3) % 16] == 8'h13, rx_buf[(n0 + 3) % 16], 8'h13);
    endtask

    task automatic t_late_byte();
        int ep0 = episodes, n0 = rx_n, t = 0;
        cfg_hold = 16'd30;
        push(8'h5A);
        while (rx_n == n0 && t < 2000) begin @(negedge clk); t++; end
        repeat (DIV/2 + 6) @(negedge clk);
        check("R5 still owning bus in hold", de == 1, de, 1);
        push(8'hC3);
        wait_release(ep0);
        check("R5 single release for late byte", episodes == ep0 + 1, episodes - ep0, 1);
        check("R5 late byte value", rx_buf[(n0 + 1) % 16] == 8'hC3, rx_buf[(n0 + 1) % 16], 8'hC3);
        cfg_hold = 16'd5;
    endtask

    task automatic t_break();
        int ep0 = episodes;
        rx_on = 0;
        @(negedge clk); brk_req = 1'b1;
        @(negedge clk); brk_req = 1'b0;
        wait_release(ep0);
        check("R9 break low length", last_low == 3 * DIV, last_low, 3 * DIV);
        check("R9 de length", de_len == (LEAD + 3 + 1) * DIV + 6, de_len, (LEAD + 4) * DIV + 6);
        check("R9 lead before break", lead_meas == LEAD * DIV, lead_meas, LEAD * DIV);
        rx_on = 1;
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (30) @(negedge clk);
        t_single();
        t_burst();
        t_guard();
        t_late_byte();
        t_break();
        check("R3 R6 monitor rules", mon_bad == 0, mon_bad, 0);
        check("R2 no framing errors", rx_ferr == 0, rx_ferr, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule